// File: doc/BRIEF.md
# Dual-Edge Phase-Frequency Detector with Polarity Swap

This block compares two streams of single-cycle pulses: one from a reference divider and one from a feedback divider. It turns the timing gap between them into pump-raise and pump-lower commands for a charge-pump driver. Both inputs are synchronous to a fast sampling clock. The detector is the usual two-flop arrangement. A reference pulse sets an internal "lead" flop and a feedback pulse sets a "lag" flop. Once both flops are set, they are held together for a programmable overlap period and then cleared in the same cycle. The forced overlap keeps the driver out of the dead zone for very small phase errors.

A polarity input swaps the two commands so that the block can serve oscillators with a rising or a falling tuning slope. A 2-bit pump-current code is passed through a register. Polarity and the current code are both captured only while the detector is idle, so a pulse is never reshaped while it is active. A high-impedance flag reports the state in which neither command is driven, which is the usual state in lock. A lock flag rises after a run of comparisons whose lone-command time stays inside the overlap window.

Top module: `pfd_polar_top`

## Requirements
- R1: While reset is held and in the first cycles after its release, pump_up and pump_dn are 0, pump_hiz is 1, icp_code is 0 and locked is 0.
- R2: With pol_in captured as 0, a ref_pulse makes pump_up 1 one cycle later and a fbk_pulse makes pump_dn 1 one cycle later. A signal that is already active holds until the common clear, so a repeated pulse on its own input neither extends nor restarts it.
- R3: Once both internal flops are set, both commands stay high for exactly ovl_len cycles and then fall in the same cycle. An ovl_len of 0 acts as 1. The leading command is therefore high for lead + ovl_len cycles and the trailing one for ovl_len cycles.
- R4: When ref_pulse and fbk_pulse arrive in the same cycle, both commands are high for exactly ovl_len cycles.
- R5: Pulses on either input that arrive while both flops are set are ignored. They do not start a new command after the clear.
- R6: With pol_in captured as 1, the commands are swapped: a reference pulse drives pump_dn and a feedback pulse drives pump_up.
- R7: pump_hiz is 1 exactly when both pump_up and pump_dn are 0.
- R8: pol_in and icp_in are captured only on clock edges at which both commands are low. A change to either while a command is high has no effect until the detector returns to idle. icp_code encodes the pump current as 0 = 100 uA, 1 = 400 uA, 2 = 700 uA and 3 = 900 uA.
- R9: A comparison counts as good when the time during which exactly one command was high is no more than the effective ovl_len. locked rises at the clear of the 16th consecutive good comparison and falls at the clear of the first bad one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_pulse | input | 1 | Single-cycle pulse from the reference divider |
| fbk_pulse | input | 1 | Single-cycle pulse from the feedback divider |
| ovl_len | input | 4 | Forced overlap length in cycles (0 acts as 1); held steady during a comparison |
| pol_in | input | 1 | Output polarity; 1 swaps the pump commands |
| icp_in | input | 2 | Requested pump current code |
| pump_up | output | 1 | Raise command for the charge pump |
| pump_dn | output | 1 | Lower command for the charge pump |
| pump_hiz | output | 1 | Both commands inactive (pump output tri-stated) |
| icp_code | output | 2 | Registered pump current code |
| locked | output | 1 | Lock indication |

## Verification
Random comparisons vary which input leads, the lead distance, the overlap length (0 included) and the polarity. Measuring the width of each command and of the overlap tells a correct clear point apart from an early or late one, and tells a swapped mapping apart from a straight one. Coincident pulses separate the pure-overlap case from a lead of one cycle. Extra pulses injected during the overlap and repeated pulses on the leading input show whether stray edges are ignored. Polarity and current changes made mid-pulse show whether a command is reshaped. A long run of in-window leads followed by one wide lead shows where the lock flag counts, saturates and drops.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // pump current selection; the value order is the encoding seen on icp_code
  typedef enum logic [1:0] {
    ICP_100U = 2'd0,
    ICP_400U = 2'd1,
    ICP_700U = 2'd2,
    ICP_900U = 2'd3
  } icp_sel_e;

  localparam int unsigned PFD_OVL_W     = 4;
  localparam int unsigned PFD_LOCK_RUNS = 16;
endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core #(
  parameter int unsigned OVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             fbk_pulse,
  input  logic [OVL_W-1:0] ovl_len,
  output logic             lead_set,
  output logic             lag_set,
  output logic             cmp_done
);
  logic             lead_q, lead_d;
  logic             lag_q, lag_d;
  logic [OVL_W-1:0] ocnt_q, ocnt_d;
  logic [OVL_W-1:0] ovl_eff;
  logic             both;
  logic             ocnt_en;

  assign ovl_eff  = (ovl_len == '0) ? OVL_W'(1) : ovl_len;
  assign both     = lead_q & lag_q;
  assign cmp_done = both && (ocnt_q == ovl_eff - 1'b1);
  assign ocnt_en  = both || (ocnt_q != '0);

  always_comb begin
    if (both) begin
      // overlap phase: inputs ignored, clear together at the end
      lead_d = !cmp_done;
      lag_d  = !cmp_done;
      ocnt_d = cmp_done ? '0 : ocnt_q + 1'b1;
    end else begin
      lead_d = lead_q | ref_pulse;
      lag_d  = lag_q | fbk_pulse;
      ocnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else begin
      lead_q <= lead_d;
      lag_q  <= lag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt_q <= '0;
    end else if (ocnt_en) begin
      ocnt_q <= ocnt_d;
    end
  end

  assign lead_set = lead_q;
  assign lag_set  = lag_q;
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int unsigned OVL_W     = 4,
  parameter int unsigned LOCK_RUNS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead_set,
  input  logic             lag_set,
  input  logic             cmp_done,
  input  logic [OVL_W-1:0] ovl_len,
  output logic             locked
);
  localparam int unsigned LCW = $clog2(LOCK_RUNS + 1);
  localparam logic [LCW-1:0] RUN_MAX = LCW'(LOCK_RUNS);
  localparam logic [OVL_W:0] LONE_MAX = '1;

  logic [OVL_W:0]   lone_q, lone_d;
  logic [LCW-1:0]   run_q, run_d;
  logic [OVL_W-1:0] ovl_eff;
  logic             good;
  logic             lone_en;

  assign ovl_eff = (ovl_len == '0) ? OVL_W'(1) : ovl_len;
  assign good    = lone_q <= {1'b0, ovl_eff};
  assign lone_en = cmp_done || ((lead_set ^ lag_set) && (lone_q != LONE_MAX));

  always_comb begin
    lone_d = cmp_done ? '0 : lone_q + 1'b1;
    if (!good)              run_d = '0;
    else if (run_q == RUN_MAX) run_d = run_q;
    else                    run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lone_q <= '0;
    end else if (lone_en) begin
      lone_q <= lone_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (cmp_done) begin
      run_q <= run_d;
    end
  end

  assign locked = (run_q == RUN_MAX);
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lead_set,
  input  logic       lag_set,
  input  logic       pol_in,
  input  logic [1:0] icp_in,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       pump_hiz,
  output logic [1:0] icp_code
);
  logic     pol_q;
  icp_sel_e icp_q;
  logic     idle;

  assign idle = !lead_set && !lag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      icp_q <= ICP_100U;
    end else if (idle) begin
      pol_q <= pol_in;
      icp_q <= icp_sel_e'(icp_in);
    end
  end

  assign pump_up  = pol_q ? lag_set : lead_set;
  assign pump_dn  = pol_q ? lead_set : lag_set;
  assign pump_hiz = idle;
  assign icp_code = icp_q;
endmodule

// File: rtl/pfd_polar_top.sv
module pfd_polar_top
  import pfd_pkg::*;
#(
  parameter int unsigned OVL_W     = PFD_OVL_W,
  parameter int unsigned LOCK_RUNS = PFD_LOCK_RUNS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             fbk_pulse,
  input  logic [OVL_W-1:0] ovl_len,
  input  logic             pol_in,
  input  logic [1:0]       icp_in,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             pump_hiz,
  output logic [1:0]       icp_code,
  output logic             locked
);
  logic [1:0] rsync_q;
  logic       rst_s_n;
  logic       lead_set, lag_set, cmp_done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  pfd_edge_core #(.OVL_W(OVL_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .ref_pulse (ref_pulse),
    .fbk_pulse (fbk_pulse),
    .ovl_len   (ovl_len),
    .lead_set  (lead_set),
    .lag_set   (lag_set),
    .cmp_done  (cmp_done)
  );

  pfd_lock_mon #(.OVL_W(OVL_W), .LOCK_RUNS(LOCK_RUNS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .lead_set (lead_set),
    .lag_set  (lag_set),
    .cmp_done (cmp_done),
    .ovl_len  (ovl_len),
    .locked   (locked)
  );

  pfd_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .lead_set (lead_set),
    .lag_set  (lag_set),
    .pol_in   (pol_in),
    .icp_in   (icp_in),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .pump_hiz (pump_hiz),
    .icp_code (icp_code)
  );
endmodule

// File: rtl/pfd_polar_chk.sv
module pfd_polar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pump_up,
  input logic       pump_dn,
  input logic       pump_hiz,
  input logic [1:0] icp_code,
  input logic       locked
);
  AST_FALL_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pump_up) |-> $fell(pump_dn)); // R3

  AST_IDLE_FROM_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_hiz) |-> $past(pump_up && pump_dn)); // R3

  AST_OVERLAP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn) |=> (pump_up == pump_dn)); // R5

  AST_ICP_HELD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_hiz |=> $stable(icp_code)); // R8

  AST_UNLOCK_AT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(pump_up && pump_dn)); // R9
endmodule

bind pfd_polar_top pfd_polar_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pump_up  (pump_up),
  .pump_dn  (pump_dn),
  .pump_hiz (pump_hiz),
  .icp_code (icp_code),
  .locked   (locked)
);

// File: tb/sim_pfd_polar_top.sv
module sim_pfd_polar_top;
  logic       clk;
  logic       rst_n;
  logic       ref_pulse, fbk_pulse;
  logic [3:0] ovl_len;
  logic       pol_in;
  logic [1:0] icp_in;
  logic       pump_up, pump_dn, pump_hiz, locked;
  logic [1:0] icp_code;

  int n_run;
  int n_fail;
  int good_runs;
  bit done;

  pfd_polar_top u0 (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fbk_pulse(fbk_pulse),
    .ovl_len(ovl_len), .pol_in(pol_in), .icp_in(icp_in),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .icp_code(icp_code), .locked(locked)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_ovl(input int o);
    return (o == 0) ? 1 : o;
  endfunction

  function automatic bit is_good(input int lead, input int o);
    return lead <= eff_ovl(o);
  endfunction

  // one comparison; all driving and sampling at negedges
  task automatic compare(input int lead, input bit ref_first, input bit inject,
                         input bit rep, input bit flip, input string tag);
    int  ovl;
    int  w_ref, w_fbk, w_both, hiz_bad, icp_bad;
    bit  pe;
    int  ie;
    ovl = eff_ovl(int'(ovl_len));
    pe = pol_in;
    ie = int'(icp_in);
    w_ref = 0; w_fbk = 0; w_both = 0; hiz_bad = 0; icp_bad = 0;
    for (int c = 0; c <= lead + ovl + 3; c++) begin
      @(negedge clk);
      begin
        bit r_raw, f_raw;
        r_raw = pe ? pump_dn : pump_up;
        f_raw = pe ? pump_up : pump_dn;
        if (c > 0) begin
          w_ref  += int'(r_raw);
          w_fbk  += int'(f_raw);
          w_both += int'(r_raw && f_raw);
          if (pump_hiz != !(pump_up || pump_dn)) hiz_bad++;
          if ((pump_up || pump_dn) && int'(icp_code) != ie) icp_bad++;
        end
      end
      ref_pulse = 1'b0;
      fbk_pulse = 1'b0;
      if (c == 0) begin
        if (lead == 0) begin ref_pulse = 1'b1; fbk_pulse = 1'b1; end
        else if (ref_first) ref_pulse = 1'b1;
        else fbk_pulse = 1'b1;
      end
      if (c == lead && lead != 0) begin
        if (ref_first) fbk_pulse = 1'b1; else ref_pulse = 1'b1;
      end
      if (rep && c == 1 && lead >= 2) begin
        if (ref_first) ref_pulse = 1'b1; else fbk_pulse = 1'b1;
      end
      if (inject && c == lead + 1) begin ref_pulse = 1'b1; fbk_pulse = 1'b1; end
      if (flip && c == 1) begin pol_in = ~pol_in; icp_in = icp_in + 2'd1; end
    end
    @(negedge clk);
    ref_pulse = 1'b0; fbk_pulse = 1'b0;
    check(w_ref == (ref_first ? lead : 0) + ovl,
          {tag, " R2 R3 R6 ref-driven command width"}, w_ref, (ref_first ? lead : 0) + ovl);
    check(w_fbk == (ref_first ? 0 : lead) + ovl,
          {tag, " R2 R3 R6 fbk-driven command width"}, w_fbk, (ref_first ? 0 : lead) + ovl);
    check(w_both == ovl, {tag, " R3 R4 R5 overlap width"}, w_both, ovl);
    check(hiz_bad == 0, {tag, " R7 hiz mismatches"}, hiz_bad, 0);
    check(icp_bad == 0, {tag, " R8 icp held during pulse"}, icp_bad, 0);
    if (is_good(lead, int'(ovl_len))) good_runs = (good_runs < 16) ? good_runs + 1 : 16;
    else good_runs = 0;
    check(locked == (good_runs == 16), {tag, " R9 lock flag"}, int'(locked), int'(good_runs == 16));
  endtask

  task automatic setup(input int o, input bit p, input int i);
    @(negedge clk);
    ovl_len = 4'(o); pol_in = p; icp_in = 2'(i);
    @(negedge clk);
    @(negedge clk);
    check(int'(icp_code) == i, "R8 icp_code captured while idle", int'(icp_code), i);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    n_run = 0; n_fail = 0; good_runs = 0; done = 0;
    rst_n = 1'b0; ref_pulse = 1'b0; fbk_pulse = 1'b0;
    ovl_len = 4'd2; pol_in = 1'b0; icp_in = 2'd3;
    repeat (3) @(negedge clk);
    check(!pump_up && !pump_dn && pump_hiz && icp_code == 2'd0 && !locked,
          "R1 outputs in reset", {pump_up, pump_dn, pump_hiz, icp_code, locked}, 6'b001000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pump_up && !pump_dn && pump_hiz && !locked, "R1 just after release",
          {pump_up, pump_dn, pump_hiz, locked}, 4'b0010);
    repeat (3) @(negedge clk);

    // directed corners
    setup(2, 0, 1); compare(3, 1, 0, 0, 0, "dir ref-lead");          // R2
    setup(2, 0, 2); compare(0, 1, 0, 0, 0, "dir same-cycle");        // R4
    setup(3, 0, 0); compare(2, 0, 1, 0, 0, "dir inject");            // R5
    setup(1, 0, 0); compare(0, 1, 1, 0, 0, "dir inject ovl1");       // R5
    setup(2, 1, 3); compare(4, 1, 0, 1, 0, "dir pol swap repeat");   // R6 R2
    setup(0, 0, 1); compare(1, 0, 0, 0, 0, "dir ovl zero");          // R3
    setup(2, 0, 0); compare(3, 1, 0, 0, 1, "dir flip mid-pulse");    // R8
    check(pol_in == 1'b1, "R8 flip applied to pol_in", int'(pol_in), 1);
    compare(2, 1, 0, 0, 0, "dir after flip");                        // R6 R8

    // lock run: in-window leads, then one wide lead
    setup(2, 0, 1);
    for (int k = 0; k < 18; k++) compare(k % 3, k[0], 0, 0, 0, "lock run"); // R9
    check(locked == 1'b1, "R9 locked after run", int'(locked), 1);
    compare(6, 1, 0, 0, 0, "lock break");                            // R9
    check(locked == 1'b0, "R9 unlocked after wide lead", int'(locked), 0);

    // constrained random mix
    for (int k = 0; k < 300; k++) begin
      int o, l;
      o = int'($urandom_range(0, 4));
      l = int'($urandom_range(0, 6));
      setup(o, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
      compare(l, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "rand");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule